// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block takes write cycles from a host bus and turns them into requests for a block-erasable flash array of `NUM_BLOCKS` blocks. It decodes one-cycle commands and two-cycle sequences from the low data byte. It keeps track of what a read returns: array data, identifier codes, the compatible status byte, or the extended status registers. Program and erase requests pass to a small internal operation engine. That engine stays busy for a fixed number of clock cycles, set by parameter, and an erase can be paused and resumed.

The block holds three kinds of status: a compatible status byte, a global status byte and one status byte per block. Each block also has a lock bit. Lock bits are only enforced while the protect input is low. A refused program or erase produces no request and sets sticky error flags. The busy output works like an open-drain ready/busy pin: it is pulled low only while an operation is actually counting.

The host bus is synchronous to `clk`. A write is committed on the clock edge where `wr_en_n` is sampled low after having been high. Array data comes from the array through `arr_rdata`. Accepted operations leave the block as a one-cycle `op_go` pulse, together with the address, data and kind of the operation.

Top module: `flash_cmd_seq`

## Requirements
- R1: The block is selected only while both `en_a_n` and `en_b_n` are low. A write is taken only while selected with `rd_en_n` high. `rdata_oe` is high only while selected with `rd_en_n` low, and `rdata` is 0 whenever `rdata_oe` is low.
- R2: Commands are decoded from `wdata[7:0]`, and `wdata[15:8]` is ignored. The single-cycle mode commands are: FFh for array read, 90h for identifier read, 70h for compatible status read and 71h for extended status read. Array read returns `arr_rdata`. In byte mode it returns `{8'h00, byte}`, where `addr[0]`=1 picks the high byte.
- R3: Identifier reads return 0089h (manufacturer) or 66A0h (device) in word mode, selected by `addr[1]`. In byte mode they return 0089h or 00A0h, selected by `addr[0]`.
- R4: 40h or 10h followed by one more write starts a program. In the cycle of the second write, `op_go`=1 and `op_erase`=0, and `op_addr`/`op_wdata` carry that write. In byte mode `op_byte`=1 and `op_wdata`={8'h00,wdata[7:0]}. Then `busy_n` is low for exactly `PGM_CYCLES` cycles, and reads return the compatible status byte.
- R5: 20h followed by D0h starts an erase of the addressed block (`op_go`=1, `op_erase`=1), which is busy for `ERASE_CYCLES` cycles. If the second byte is not D0h, no operation starts and compatible status bits 5 and 4 are set.
- R6: 77h followed by D0h sets the lock bit (block status bit 6) of the block in `addr[ADDR_W-1 -: log2(NUM_BLOCKS)]`.
- R7: While `protect_n` is low, a program or erase to a locked block gives no `op_go`. It sets compatible status bit 4 (program) or bit 5 (erase), global status bit 5, and bit 5 of that block's status. While `protect_n` is high, locked blocks are programmed or erased normally.
- R8: 50h clears compatible status bits 5, 4 and 3, global status bit 5, and bits 5, 4 and 2 of every block status. Lock bits are unaffected.
- R9: B0h during a counting erase releases `busy_n` and sets compatible and global status bit 6. The remaining time is frozen. D0h resumes the erase, so the total low time of `busy_n` equals `ERASE_CYCLES`.
- R10: In extended status mode, byte offset 2 within the addressed block returns that block's status and byte offset 4 returns the global status. In word mode `addr[0]` is ignored. Any other offset returns 0.
- R11: `rst_n` low aborts any operation, releases `busy_n` at once, clears all status flags and lock bits, and returns reads to array mode.
- R12: The second write of a program, erase or lock sequence that arrives while an operation is busy or suspended is dropped: no `op_go`, and no flag is set.
- R13: Compatible and global status bit 7 are 0 only while an operation is counting. Block status bit 7 is 0 only for the block being operated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset / power-down, active low |
| en_a_n | input | 1 | First select, active low |
| en_b_n | input | 1 | Second select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| protect_n | input | 1 | 0 = lock bits enforced |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write data / command |
| arr_rdata | input | 16 | Word read from the array at `addr` |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Read data valid / driven |
| busy_n | output | 1 | Low while an operation counts |
| op_go | output | 1 | One-cycle operation request |
| op_erase | output | 1 | 1 = erase, 0 = program |
| op_byte | output | 1 | Program is a byte write |
| op_addr | output | ADDR_W | Operation address |
| op_wdata | output | 16 | Program data |

## Verification
The bench attacks the second cycle of two-cycle sequences: a wrong confirm byte, a confirm arriving while an erase runs, and a program aimed at a locked block with protection on and off. A design that skipped the confirm check would erase on garbage. One that ignored the busy state would emit a second request in the middle of an operation. One that mixed up the lock gating would either refuse every write or refuse none. Suspend and resume are timed by counting every low cycle of `busy_n`, so a timer that slips or restarts on resume shows up as a wrong total. The clear command is checked against a surviving lock bit, which catches a clear that is too broad. The bench also checks the gating by select and output enable, the identifier byte selection in both bus widths, and a reset in the middle of an erase.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_CSR, RM_XSR} rmode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PGM, SQ_ERASE, SQ_LOCK} seq_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_IDENT    = 8'h90;
  localparam logic [7:0] C_RD_CSR   = 8'h70;
  localparam logic [7:0] C_RD_XSR   = 8'h71;
  localparam logic [7:0] C_CLEAR    = 8'h50;
  localparam logic [7:0] C_PGM_A    = 8'h40;
  localparam logic [7:0] C_PGM_B    = 8'h10;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_LOCK     = 8'h77;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;

  // identifier word; byte mode returns only the low byte of each code
  function automatic logic [15:0] ident_word(input logic dev_sel, input logic bytem);
    logic [15:0] w;
    w = dev_sel ? 16'h66A0 : 16'h0089;
    return bytem ? {8'h00, w[7:0]} : w;
  endfunction

  // status byte layout shared by all three register kinds
  function automatic logic [7:0] status_byte(input logic rdy, input logic b6,
                                             input logic b5, input logic b4);
    return {rdy, b6, b5, b4, 4'b0000};
  endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] cmd,
  output rmode_e     mode,
  output logic       ev_pgm,
  output logic       ev_erase,
  output logic       ev_lock,
  output logic       ev_seqerr,
  output logic       ev_clear,
  output logic       ev_susp,
  output logic       ev_resume
);
  seq_e   seq_q;
  rmode_e mode_q;

  assign mode = mode_q;

  always_comb begin
    ev_pgm = 1'b0; ev_erase = 1'b0; ev_lock = 1'b0; ev_seqerr = 1'b0;
    ev_clear = 1'b0; ev_susp = 1'b0; ev_resume = 1'b0;
    if (wr_stb) begin
      case (seq_q)
        SQ_PGM:   ev_pgm = 1'b1;
        SQ_ERASE: begin ev_erase = (cmd == C_CONFIRM); ev_seqerr = (cmd != C_CONFIRM); end
        SQ_LOCK:  begin ev_lock  = (cmd == C_CONFIRM); ev_seqerr = (cmd != C_CONFIRM); end
        default: begin
          ev_clear  = (cmd == C_CLEAR);
          ev_susp   = (cmd == C_SUSPEND);
          ev_resume = (cmd == C_CONFIRM);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      mode_q <= RM_ARRAY;
    end else if (wr_stb) begin
      if (seq_q != SQ_IDLE) begin
        seq_q  <= SQ_IDLE;
        mode_q <= RM_CSR;
      end else begin
        case (cmd)
          C_RD_ARRAY:       mode_q <= RM_ARRAY;
          C_IDENT:          mode_q <= RM_IDENT;
          C_RD_CSR:         mode_q <= RM_CSR;
          C_RD_XSR:         mode_q <= RM_XSR;
          C_PGM_A, C_PGM_B: begin seq_q <= SQ_PGM;   mode_q <= RM_CSR; end
          C_ERASE:          begin seq_q <= SQ_ERASE; mode_q <= RM_CSR; end
          C_LOCK:           begin seq_q <= SQ_LOCK;  mode_q <= RM_CSR; end
          C_SUSPEND:        mode_q <= RM_CSR;
          default:          ;
        endcase
      end
    end
  end

  // R2
  array_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && seq_q == SQ_IDLE && cmd == C_RD_ARRAY) |=> (mode == RM_ARRAY));

endmodule

// File: rtl/fcs_wsm.sv
module fcs_wsm #(
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 20,
  parameter int BLK_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_erase,
  input  logic [BLK_W-1:0] start_blk,
  input  logic             susp_req,
  input  logic             resume_req,
  output logic             busy,
  output logic             suspended,
  output logic             running,
  output logic [BLK_W-1:0] op_blk
);
  localparam int MAXC  = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  function automatic logic [CNT_W-1:0] load_val(input logic erase);
    return erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PGM_CYCLES);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             erase_q;

  assign running = busy && !suspended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; suspended <= 1'b0; cnt_q <= '0;
      erase_q <= 1'b0; op_blk <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1; suspended <= 1'b0;
      cnt_q <= load_val(start_erase);
      erase_q <= start_erase; op_blk <= start_blk;
    end else if (running) begin
      if (cnt_q == CNT_W'(1)) begin
        busy <= 1'b0; cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (susp_req && erase_q) suspended <= 1'b1;
      end
    end else if (busy && resume_req) begin
      suspended <= 1'b0;
    end
  end

  // R9
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume_req) |=> $stable(cnt_q));
  // R13
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q != '0));

endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import fcs_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int BLK_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  lock_set,
  input  logic                  err_pgm,
  input  logic                  err_erase,
  input  logic                  err_blk_set,
  input  logic [BLK_W-1:0]      blk,
  input  logic                  running,
  input  logic                  suspended,
  input  logic [BLK_W-1:0]      act_blk,
  output logic [7:0]            csr,
  output logic [7:0]            gsr,
  output logic [7:0]            bsr_rd,
  output logic [NUM_BLOCKS-1:0] lock_vec
);
  logic                  pgm_err_q, ers_err_q, dev_err_q;
  logic [NUM_BLOCKS-1:0] blk_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_err_q <= 1'b0; ers_err_q <= 1'b0; dev_err_q <= 1'b0;
    end else if (clear) begin
      pgm_err_q <= 1'b0; ers_err_q <= 1'b0; dev_err_q <= 1'b0;
    end else begin
      if (err_pgm)              pgm_err_q <= 1'b1;
      if (err_erase)            ers_err_q <= 1'b1;
      if (err_pgm || err_erase) dev_err_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_vec[g]  <= 1'b0;
        blk_err_q[g] <= 1'b0;
      end else begin
        if (lock_set && blk == BLK_W'(g)) lock_vec[g] <= 1'b1;
        if (clear) blk_err_q[g] <= 1'b0;
        else if (err_blk_set && blk == BLK_W'(g)) blk_err_q[g] <= 1'b1;
      end
    end
  end

  assign csr    = status_byte(!running, suspended, ers_err_q, pgm_err_q);
  assign gsr    = status_byte(!running, suspended, dev_err_q, 1'b0);
  assign bsr_rd = status_byte(!(running && act_blk == blk), lock_vec[blk], blk_err_q[blk], 1'b0);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (csr[5:3] == 3'b000 && gsr[5] == 1'b0 && blk_err_q == '0));
  // R6
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> lock_vec[$past(blk)]);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int NUM_BLOCKS   = 32,
  parameter int ADDR_W       = 21,
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic              byte_mode,
  input  logic              protect_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       arr_rdata,
  output logic [15:0]       rdata,
  output logic              rdata_oe,
  output logic              busy_n,
  output logic              op_go,
  output logic              op_erase,
  output logic              op_byte,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_wdata
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int OFS_W = ADDR_W - BLK_W;

  // 1 = block status, 2 = global status, 0 = nothing
  function automatic logic [1:0] xsr_slot(input logic [OFS_W-1:0] ofs, input logic bytem);
    logic [OFS_W-1:0] o;
    o = bytem ? ofs : {ofs[OFS_W-1:1], 1'b0};
    if (o == OFS_W'(2)) return 2'd1;
    if (o == OFS_W'(4)) return 2'd2;
    return 2'd0;
  endfunction

  logic             sel, we_q, wr_stb;
  logic [BLK_W-1:0] blk;
  rmode_e           mode;
  logic ev_pgm, ev_erase, ev_lock, ev_seqerr, ev_clear, ev_susp, ev_resume;
  logic wsm_busy, wsm_susp, wsm_run;
  logic [BLK_W-1:0] act_blk;
  logic [7:0] csr, gsr, bsr_rd;
  logic [NUM_BLOCKS-1:0] lock_vec;
  logic guard, refuse, err_pgm, err_erase;
  logic [15:0] word;

  assign sel    = !en_a_n && !en_b_n;
  assign wr_stb = sel && rd_en_n && !wr_en_n && we_q;
  assign blk    = addr[ADDR_W-1 -: BLK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= wr_en_n;
  end

  fcs_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd(wdata[7:0]), .mode(mode),
    .ev_pgm(ev_pgm), .ev_erase(ev_erase), .ev_lock(ev_lock), .ev_seqerr(ev_seqerr),
    .ev_clear(ev_clear), .ev_susp(ev_susp), .ev_resume(ev_resume)
  );

  assign guard     = !protect_n && lock_vec[blk];
  assign refuse    = (ev_pgm || ev_erase) && !wsm_busy && guard;
  assign op_go     = (ev_pgm || ev_erase) && !wsm_busy && !guard;
  assign op_erase  = ev_erase;
  assign op_byte   = byte_mode;
  assign op_addr   = addr;
  assign op_wdata  = byte_mode ? {8'h00, wdata[7:0]} : wdata;
  assign err_pgm   = (refuse && ev_pgm) || ev_seqerr;
  assign err_erase = (refuse && ev_erase) || ev_seqerr;

  fcs_wsm #(.PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .BLK_W(BLK_W)) u_wsm (
    .clk(clk), .rst_n(rst_n), .start(op_go), .start_erase(ev_erase), .start_blk(blk),
    .susp_req(ev_susp), .resume_req(ev_resume), .busy(wsm_busy), .suspended(wsm_susp),
    .running(wsm_run), .op_blk(act_blk)
  );

  fcs_status #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clear(ev_clear), .lock_set(ev_lock && !wsm_busy),
    .err_pgm(err_pgm), .err_erase(err_erase), .err_blk_set(refuse), .blk(blk),
    .running(wsm_run), .suspended(wsm_susp), .act_blk(act_blk),
    .csr(csr), .gsr(gsr), .bsr_rd(bsr_rd), .lock_vec(lock_vec)
  );

  assign busy_n = !(rst_n && wsm_run);

  always_comb begin
    word = 16'h0000;
    case (mode)
      RM_ARRAY: word = arr_rdata;
      RM_IDENT: word = ident_word(byte_mode ? addr[0] : addr[1], byte_mode);
      RM_CSR:   word = {8'h00, csr};
      default: begin
        case (xsr_slot(addr[OFS_W-1:0], byte_mode))
          2'd1:    word = {8'h00, bsr_rd};
          2'd2:    word = {8'h00, gsr};
          default: word = 16'h0000;
        endcase
      end
    endcase
    if (byte_mode) begin
      if (mode == RM_ARRAY && addr[0]) word = {8'h00, arr_rdata[15:8]};
      else                             word[15:8] = 8'h00;
    end
  end

  assign rdata_oe = sel && !rd_en_n;
  assign rdata    = rdata_oe ? word : 16'h0000;

  // R4
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |=> !busy_n);
  // R12
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_busy && (ev_pgm || ev_erase || ev_lock)) |-> !op_go);

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int PGM_N = 6;
  localparam int ERS_N = 20;

  logic clk = 1'b0;
  logic rst_n, en_a_n, en_b_n, rd_en_n, wr_en_n, byte_mode, protect_n;
  logic [20:0] addr;
  logic [15:0] wdata, arr_rdata, rdata, op_wdata;
  logic rdata_oe, busy_n, op_go, op_erase, op_byte;
  logic [20:0] op_addr;

  int n_cmp = 0, n_bad = 0, bcnt = 0;
  logic g_go, g_erase, g_byte, g_oe;
  logic [20:0] g_addr;
  logic [15:0] g_data;
  logic [31:0] lockm;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq #(.PGM_CYCLES(PGM_N), .ERASE_CYCLES(ERS_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b_n(en_b_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .byte_mode(byte_mode), .protect_n(protect_n), .addr(addr),
    .wdata(wdata), .arr_rdata(arr_rdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .busy_n(busy_n), .op_go(op_go), .op_erase(op_erase), .op_byte(op_byte),
    .op_addr(op_addr), .op_wdata(op_wdata)
  );

  always @(negedge clk) if (rst_n === 1'b1 && busy_n === 1'b0) bcnt++;

  function automatic logic [20:0] baddr(input int b, input int ofs);
    return {b[4:0], ofs[15:0]};
  endfunction
  function automatic logic [15:0] st(input bit rdy, input bit b6, input bit b5, input bit b4);
    return 16'(rdy) << 7 | 16'(b6) << 6 | 16'(b5) << 5 | 16'(b4) << 4;
  endfunction
  function automatic logic [15:0] exp_id(input logic [20:0] a, input bit bm);
    if (bm) return a[0] ? 16'h00A0 : 16'h0089;
    return a[1] ? 16'h66A0 : 16'h0089;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en_n = 1'b0;
    #1; g_go = op_go; g_erase = op_erase; g_addr = op_addr; g_data = op_wdata; g_byte = op_byte;
    @(negedge clk); wr_en_n = 1'b1;
  endtask

  task automatic rd(input logic [20:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en_n = 1'b0;
    #1; v = rdata; g_oe = rdata_oe; rd_en_n = 1'b1;
  endtask

  task automatic wait_rdy();
    while (busy_n === 1'b0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    #1; chk("R11 busy_n in reset", busy_n, 1'b1);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    lockm = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int b0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; en_a_n = 1'b0; en_b_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b1;
    byte_mode = 1'b0; protect_n = 1'b1; addr = '0; wdata = '0; arr_rdata = 16'h1234;
    lockm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 busy_n after reset", busy_n, 1'b1);
    rd(21'h0, v); chk("R11 array mode after reset", v, 16'h1234);
    chk("R1 oe when selected", g_oe, 1'b1);

    // R2 / R3 identifier, upper byte ignored
    wr(21'h0, 16'hAB90);
    rd(21'h0, v); chk("R3 word mfr", v, exp_id(21'h0, 0));
    rd(21'h2, v); chk("R3 word dev", v, exp_id(21'h2, 0));
    byte_mode = 1'b1;
    rd(21'h0, v); chk("R3 byte mfr", v, exp_id(21'h0, 1));
    rd(21'h1, v); chk("R3 byte dev", v, exp_id(21'h1, 1));
    wr(21'h0, 16'h00FF);
    rd(21'h1, v); chk("R2 byte array high", v, 16'h0012);
    rd(21'h0, v); chk("R2 byte array low", v, 16'h0034);
    byte_mode = 1'b0;

    // R1 gating
    en_b_n = 1'b1; wr(21'h0, 16'h0070); en_b_n = 1'b0;
    rd(21'h0, v); chk("R1 write ignored when deselected", v, 16'h1234);
    rd_en_n = 1'b0; wr(21'h0, 16'h0090); rd_en_n = 1'b1;
    rd(21'h0, v); chk("R1 write ignored under output enable", v, 16'h1234);
    en_a_n = 1'b1; rd(21'h0, v);
    chk("R1 oe low when deselected", g_oe, 1'b0); chk("R1 rdata zero", v, 16'h0);
    en_a_n = 1'b0;

    // R4 program
    b0 = bcnt;
    wr(baddr(2, 16'h0010), 16'h0040);
    wr(baddr(2, 16'h0010), 16'hBEEF);
    chk("R4 go", g_go, 1'b1); chk("R4 kind", g_erase, 1'b0);
    chk("R4 addr", g_addr, baddr(2, 16'h0010)); chk("R4 data", g_data, 16'hBEEF);
    chk("R4 busy_n low", busy_n, 1'b0);
    rd(21'h0, v); chk("R13 csr busy", v, st(0, 0, 0, 0));
    wait_rdy();
    chk("R4 busy length", bcnt - b0, PGM_N);
    rd(21'h0, v); chk("R13 csr ready", v, st(1, 0, 0, 0));

    // R5 erase + R10/R13 extended status while busy
    b0 = bcnt;
    wr(baddr(3, 0), 16'h0020); wr(baddr(3, 0), 16'h00D0);
    chk("R5 go", g_go, 1'b1); chk("R5 kind", g_erase, 1'b1);
    wr(21'h0, 16'h0071);
    rd(baddr(3, 2), v); chk("R13 bsr active block", v, st(0, 0, 0, 0));
    rd(baddr(4, 3), v); chk("R10 bsr other block odd addr", v, st(1, 0, 0, 0));
    rd(baddr(0, 4), v); chk("R10 gsr busy", v, st(0, 0, 0, 0));
    rd(baddr(0, 6), v); chk("R10 empty slot", v, 16'h0);
    wait_rdy();
    chk("R5 busy length", bcnt - b0, ERS_N);
    rd(baddr(0, 4), v); chk("R10 gsr ready", v, st(1, 0, 0, 0));

    // R5 bad confirm, R8 clear
    wr(baddr(3, 0), 16'h0020); wr(baddr(3, 0), 16'h00FF);
    chk("R5 no go on bad confirm", g_go, 1'b0);
    rd(21'h0, v); chk("R5 csr seq error", v, st(1, 0, 1, 1));
    wr(21'h0, 16'h0050);
    rd(21'h0, v); chk("R8 csr cleared", v, st(1, 0, 0, 0));

    // R6 lock, R7 protect
    wr(baddr(5, 0), 16'h0077); wr(baddr(5, 0), 16'h00D0);
    wr(21'h0, 16'h0071);
    rd(baddr(5, 2), v); chk("R6 lock bit", v, st(1, 1, 0, 0));
    protect_n = 1'b0; b0 = bcnt;
    wr(baddr(5, 8), 16'h0040); wr(baddr(5, 8), 16'h1111);
    chk("R7 locked program refused", g_go, 1'b0);
    rd(21'h0, v); chk("R7 csr program error", v, st(1, 0, 0, 1));
    wr(21'h0, 16'h0071);
    rd(baddr(5, 2), v); chk("R7 bsr error", v, st(1, 1, 1, 0));
    rd(baddr(6, 2), v); chk("R7 other bsr clean", v, st(1, 0, 0, 0));
    rd(baddr(0, 4), v); chk("R7 gsr error", v, st(1, 0, 1, 0));
    wr(baddr(5, 0), 16'h0020); wr(baddr(5, 0), 16'h00D0);
    chk("R7 locked erase refused", g_go, 1'b0);
    rd(21'h0, v); chk("R7 csr erase error", v, st(1, 0, 1, 1));
    chk("R7 never busy", bcnt - b0, 0);
    protect_n = 1'b1;
    wr(baddr(5, 8), 16'h0040); wr(baddr(5, 8), 16'h2222);
    chk("R7 unprotected program", g_go, 1'b1);
    wait_rdy();
    wr(21'h0, 16'h0050); wr(21'h0, 16'h0071);
    rd(baddr(5, 2), v); chk("R8 lock survives clear", v, st(1, 1, 0, 0));
    rd(baddr(0, 4), v); chk("R8 gsr cleared", v, st(1, 0, 0, 0));

    // R9 suspend / resume
    b0 = bcnt;
    wr(baddr(7, 0), 16'h0020); wr(baddr(7, 0), 16'h00D0);
    repeat (5) @(negedge clk);
    wr(21'h0, 16'h00B0);
    chk("R9 released on suspend", busy_n, 1'b1);
    rd(21'h0, v); chk("R9 csr suspended", v, st(1, 1, 0, 0));
    repeat (10) @(negedge clk);
    chk("R9 still released", busy_n, 1'b1);
    wr(21'h0, 16'h00D0);
    chk("R9 busy after resume", busy_n, 1'b0);
    wait_rdy();
    chk("R9 total erase time", bcnt - b0, ERS_N);

    // R12 second cycle during busy dropped
    b0 = bcnt;
    wr(baddr(8, 0), 16'h0020); wr(baddr(8, 0), 16'h00D0);
    wr(baddr(9, 0), 16'h0040); wr(baddr(9, 0), 16'h3333);
    chk("R12 program dropped", g_go, 1'b0);
    wait_rdy();
    chk("R12 no extra busy", bcnt - b0, ERS_N);
    rd(21'h0, v); chk("R12 no flag", v, st(1, 0, 0, 0));

    // R11 reset mid-operation
    wr(baddr(10, 0), 16'h0020); wr(baddr(10, 0), 16'h00D0);
    repeat (3) @(negedge clk);
    do_reset();
    rd(21'h0, v); chk("R11 array after abort", v, 16'h1234);
    wr(21'h0, 16'h0071);
    rd(baddr(5, 2), v); chk("R11 lock cleared", v, st(1, 0, 0, 0));

    // randomised programs against lock/protect model
    for (int i = 0; i < 40; i++) begin
      int b; bit bm, refuse;
      logic [15:0] d, ed;
      b = $urandom_range(0, 31);
      if ($urandom_range(0, 3) == 0 && !lockm[b]) begin
        wr(baddr(b, 0), 16'h0077); wr(baddr(b, 0), 16'h00D0);
        lockm[b] = 1'b1;
      end
      protect_n = 1'($urandom_range(0, 1));
      bm = 1'($urandom_range(0, 1));
      byte_mode = bm;
      d = 16'($urandom);
      ed = bm ? {8'h00, d[7:0]} : d;
      refuse = !protect_n && lockm[b];
      wr(baddr(b, 16'h0100), 16'h0010); wr(baddr(b, 16'h0100), d);
      chk("R7 random go", g_go, !refuse);
      if (!refuse) begin
        chk("R4 random data", g_data, ed);
        chk("R4 random byte flag", g_byte, bm);
      end
      wait_rdy();
      rd(21'h0, v); chk("R7 random csr", v, st(1, 0, 0, refuse));
      wr(21'h0, 16'h0050);
    end
    byte_mode = 1'b0; protect_n = 1'b1;

    summary();
    $finish;
  end
endmodule